// File: doc/BRIEF.md
# Banked Stack/Link Register Mode Switcher

This block keeps the live stack pointer (R13) and link register (R14) of a processor with seven privilege modes, together with a private R13/R14 pair for each mode that owns one. It also holds one saved-status slot per exception mode and the live saved-status copy. A mode-change request exchanges the live state with the banks in a single clock edge. The outgoing mode's bank receives the current R13/R14 and, for an exception mode, the live saved-status copy. In the same edge the incoming mode's bank is loaded into the live registers, and the mode field of the current status register is rewritten.

The surrounding core reads R13, R14, the status register and the live saved-status copy directly from the outputs. It writes R13/R14 through a single write port, and writes the live saved-status copy and the non-mode bits of the status register through their own write enables. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `bank_mode_switch`

## Requirements
- R1: While in reset and after its release, R13 is 0x10000000, R14 is 0, the live saved-status copy is 0, and the status register is 0xD3. That value is mode field [4:0] = supervisor 0x13, with the IRQ mask at bit 7 and the FIQ mask at bit 6 both set.
- R2: Mode codes are 0x10 user, 0x11 FIQ, 0x12 IRQ, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system. A request for a known mode other than the current one sets status[4:0] to that code one edge later and leaves status[31:5] unchanged.
- R3: On a switch, the live R13/R14 are stored into the outgoing mode's bank and the incoming mode's pair becomes live on the same edge. Returning to a mode restores the values it held when it was left.
- R4: Leaving an exception mode (FIQ, IRQ, supervisor, abort or undefined) stores the live saved-status copy into that mode's slot. Entering one loads its slot into the live copy.
- R5: A request for the mode that is already active changes nothing.
- R6: A request with a code outside the seven listed in R2 changes nothing.
- R7: User and system modes share one R13/R14 pair, so switching between them keeps R13/R14. Neither mode has a saved-status slot: entering either mode leaves the live saved-status copy as it was, and a saved-status write in either mode is ignored.
- R8: If a mode switch and a register or saved-status write occur in the same cycle, the switch is applied first. The write lands in the new mode's live register, and the outgoing bank keeps the value from before the write.
- R9: A status write replaces status[31:5] only. The mode field [4:0] is changed only by a mode request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_req_valid | input | 1 | Mode-change request strobe |
| mode_req_code | input | 5 | Requested mode code |
| reg_wr_en | input | 1 | Write enable for R13/R14 |
| reg_wr_sel | input | 1 | 0 selects R13, 1 selects R14 |
| reg_wr_data | input | DW | Write data for R13/R14 |
| saved_wr_en | input | 1 | Write enable for the live saved-status copy |
| saved_wr_data | input | SW | Write data for the live saved-status copy |
| stat_wr_en | input | 1 | Write enable for status bits above the mode field |
| stat_wr_data | input | SW-5 | New value for status[SW-1:5] |
| r13_o | output | DW | Live stack pointer |
| r14_o | output | DW | Live link register |
| stat_o | output | SW | Current status register |
| saved_o | output | SW | Live saved-status copy |

## Verification
Every result of a request or write is registered once. The new R13, R14, saved-status copy and status value are all visible after the first rising edge that samples the stimulus. The bench drives each stimulus on a falling edge, lets one rising edge pass, and reads the outputs on the following falling edge. The outputs are then settled, and the next stimulus has not yet been taken. Each ignored request is confirmed by reading all four outputs in that same slot. The R3, R4 and R7 checks switch back to a mode that was left earlier and compare the restored values.

// File: rtl/bms_pkg.sv
package bms_pkg;
  localparam int MODE_W     = 5;
  localparam int NUM_BANKS  = 6;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  typedef logic [BANK_IDX_W-1:0] bank_idx_t;

  // bank 0 is shared by user and system and has no saved-status slot
  localparam bank_idx_t BANK_USR = 3'd0;
  localparam bank_idx_t BANK_FIQ = 3'd1;
  localparam bank_idx_t BANK_IRQ = 3'd2;
  localparam bank_idx_t BANK_SVC = 3'd3;
  localparam bank_idx_t BANK_ABT = 3'd4;
  localparam bank_idx_t BANK_UND = 3'd5;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic bank_idx_t bank_of(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BANK_FIQ;
      MODE_IRQ: return BANK_IRQ;
      MODE_SVC: return BANK_SVC;
      MODE_ABT: return BANK_ABT;
      MODE_UND: return BANK_UND;
      default:  return BANK_USR;
    endcase
  endfunction

  function automatic logic bank_has_saved(input bank_idx_t b);
    return b != BANK_USR;
  endfunction
endpackage

// File: rtl/bms_mode_decode.sv
module bms_mode_decode
  import bms_pkg::*;
(
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_code,
  output logic              sw_en,
  output bank_idx_t         old_bank,
  output bank_idx_t         new_bank,
  output logic              old_saved,
  output logic              new_saved,
  output logic              same_bank
);
  always_comb begin
    old_bank  = bank_of(cur_mode);
    new_bank  = bank_of(req_code);
    old_saved = bank_has_saved(old_bank);
    new_saved = bank_has_saved(new_bank);
    same_bank = (old_bank == new_bank);
    sw_en     = req_valid && mode_known(req_code) && (req_code != cur_mode);
  end
endmodule

// File: rtl/bms_bank_store.sv
module bms_bank_store
  import bms_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_en,
  input  bank_idx_t     save_idx,
  input  logic [DW-1:0] save_sp,
  input  logic [DW-1:0] save_lr,
  input  logic          save_sts_en,
  input  logic [SW-1:0] save_sts,
  input  bank_idx_t     load_idx,
  output logic [DW-1:0] load_sp,
  output logic [DW-1:0] load_lr,
  output logic [SW-1:0] load_sts
);
  logic [DW-1:0] sp_vec  [NUM_BANKS];
  logic [DW-1:0] lr_vec  [NUM_BANKS];
  logic [SW-1:0] sts_vec [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic          hit;
    logic [DW-1:0] sp_r;
    logic [DW-1:0] lr_r;

    assign hit = save_en && (save_idx == bank_idx_t'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sp_r <= '0;
        lr_r <= '0;
      end else if (hit) begin
        sp_r <= save_sp;
        lr_r <= save_lr;
      end
    end

    assign sp_vec[b] = sp_r;
    assign lr_vec[b] = lr_r;

    if (b == int'(BANK_USR)) begin : g_no_sts
      assign sts_vec[b] = '0;
    end else begin : g_sts
      logic [SW-1:0] sts_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   sts_r <= '0;
        else if (hit && save_sts_en)  sts_r <= save_sts;
      end
      assign sts_vec[b] = sts_r;
    end
  end

  always_comb begin
    load_sp  = sp_vec[load_idx];
    load_lr  = lr_vec[load_idx];
    load_sts = sts_vec[load_idx];
  end
endmodule

// File: rtl/bank_mode_switch.sv
module bank_mode_switch
  import bms_pkg::*;
#(
  parameter int            DW           = 32,
  parameter int            SW           = 32,
  parameter logic [DW-1:0] SP_RESET     = 32'h1000_0000,
  parameter int            IRQ_MASK_BIT = 7,
  parameter int            FIQ_MASK_BIT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_req_valid,
  input  logic [MODE_W-1:0]    mode_req_code,
  input  logic                 reg_wr_en,
  input  logic                 reg_wr_sel,
  input  logic [DW-1:0]        reg_wr_data,
  input  logic                 saved_wr_en,
  input  logic [SW-1:0]        saved_wr_data,
  input  logic                 stat_wr_en,
  input  logic [SW-MODE_W-1:0] stat_wr_data,
  output logic [DW-1:0]        r13_o,
  output logic [DW-1:0]        r14_o,
  output logic [SW-1:0]        stat_o,
  output logic [SW-1:0]        saved_o
);
  localparam logic [SW-1:0] STAT_RESET = (SW'(1) << IRQ_MASK_BIT) |
                                         (SW'(1) << FIQ_MASK_BIT) |
                                         SW'(MODE_SVC);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [DW-1:0] sp_q, sp_d, lr_q, lr_d;
  logic [SW-1:0] sv_q, sv_d, st_q, st_d;

  logic      sw_en, old_saved, new_saved, same_bank, next_saved;
  bank_idx_t old_bank, new_bank;
  logic [DW-1:0] ld_sp, ld_lr;
  logic [SW-1:0] ld_sts;

  bms_mode_decode u_dec (
    .cur_mode  (st_q[MODE_W-1:0]),
    .req_valid (mode_req_valid),
    .req_code  (mode_req_code),
    .sw_en     (sw_en),
    .old_bank  (old_bank),
    .new_bank  (new_bank),
    .old_saved (old_saved),
    .new_saved (new_saved),
    .same_bank (same_bank)
  );

  bms_bank_store #(.DW(DW), .SW(SW)) u_banks (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .save_en     (sw_en),
    .save_idx    (old_bank),
    .save_sp     (sp_q),
    .save_lr     (lr_q),
    .save_sts_en (old_saved),
    .save_sts    (sv_q),
    .load_idx    (new_bank),
    .load_sp     (ld_sp),
    .load_lr     (ld_lr),
    .load_sts    (ld_sts)
  );

  // saved-status writes land only when the mode in force after this edge has a slot
  assign next_saved = sw_en ? new_saved : old_saved;

  always_comb begin
    sp_d = sp_q;
    lr_d = lr_q;
    sv_d = sv_q;
    st_d = st_q;
    // swap first
    if (sw_en) begin
      if (!same_bank) begin
        sp_d = ld_sp;
        lr_d = ld_lr;
      end
      if (new_saved) sv_d = ld_sts;
      st_d[MODE_W-1:0] = mode_req_code;
    end
    // then writes, aimed at the mode in force after the swap
    if (reg_wr_en) begin
      if (reg_wr_sel) lr_d = reg_wr_data;
      else            sp_d = reg_wr_data;
    end
    if (saved_wr_en && next_saved) sv_d = saved_wr_data;
    if (stat_wr_en) st_d[SW-1:MODE_W] = stat_wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sp_q <= SP_RESET;
      lr_q <= '0;
      sv_q <= '0;
      st_q <= STAT_RESET;
    end else begin
      sp_q <= sp_d;
      lr_q <= lr_d;
      sv_q <= sv_d;
      st_q <= st_d;
    end
  end

  assign r13_o   = sp_q;
  assign r14_o   = lr_q;
  assign stat_o  = st_q;
  assign saved_o = sv_q;
endmodule

// File: rtl/bms_checker.sv
module bms_checker
  import bms_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_req_valid,
  input logic [MODE_W-1:0] mode_req_code,
  input logic              reg_wr_en,
  input logic              reg_wr_sel,
  input logic [DW-1:0]     reg_wr_data,
  input logic              saved_wr_en,
  input logic              stat_wr_en,
  input logic [DW-1:0]     r13_o,
  input logic [DW-1:0]     r14_o,
  input logic [SW-1:0]     stat_o,
  input logic [SW-1:0]     saved_o
);
  logic quiet;
  logic us_pair;
  assign quiet   = !reg_wr_en && !saved_wr_en && !stat_wr_en;
  assign us_pair = (stat_o[MODE_W-1:0] == MODE_USR || stat_o[MODE_W-1:0] == MODE_SYS) &&
                   (mode_req_code == MODE_USR || mode_req_code == MODE_SYS);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_known(stat_o[MODE_W-1:0])); // R2

  AST_MODE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req_valid && mode_known(mode_req_code))
      |=> stat_o[MODE_W-1:0] == $past(mode_req_code)); // R2

  AST_UPPER_STAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr_en |=> stat_o[SW-1:MODE_W] == $past(stat_o[SW-1:MODE_W])); // R9

  AST_SAME_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req_valid && mode_req_code == stat_o[MODE_W-1:0] && quiet)
      |=> $stable(r13_o) && $stable(r14_o) && $stable(stat_o) && $stable(saved_o)); // R5

  AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req_valid && !mode_known(mode_req_code) && quiet)
      |=> $stable(r13_o) && $stable(r14_o) && $stable(stat_o) && $stable(saved_o)); // R6

  AST_USR_SYS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req_valid && us_pair && quiet)
      |=> $stable(r13_o) && $stable(r14_o) && $stable(saved_o)); // R7

  AST_WRITE_AFTER_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wr_sel) |=> r13_o == $past(reg_wr_data)); // R8
endmodule

bind bank_mode_switch bms_checker #(.DW(DW), .SW(SW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .mode_req_valid (mode_req_valid),
  .mode_req_code  (mode_req_code),
  .reg_wr_en      (reg_wr_en),
  .reg_wr_sel     (reg_wr_sel),
  .reg_wr_data    (reg_wr_data),
  .saved_wr_en    (saved_wr_en),
  .stat_wr_en     (stat_wr_en),
  .r13_o          (r13_o),
  .r14_o          (r14_o),
  .stat_o         (stat_o),
  .saved_o        (saved_o)
);

// File: tb/bank_mode_switch_tb.sv
module bank_mode_switch_tb;
  localparam int DW = 32;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_req_valid;
  logic [4:0]    mode_req_code;
  logic          reg_wr_en;
  logic          reg_wr_sel;
  logic [DW-1:0] reg_wr_data;
  logic          saved_wr_en;
  logic [SW-1:0] saved_wr_data;
  logic          stat_wr_en;
  logic [SW-6:0] stat_wr_data;
  logic [DW-1:0] r13_o, r14_o;
  logic [SW-1:0] stat_o, saved_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bank_mode_switch #(.DW(DW), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .mode_req_valid(mode_req_valid), .mode_req_code(mode_req_code),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
    .r13_o(r13_o), .r14_o(r14_o), .stat_o(stat_o), .saved_o(saved_o)
  );

  localparam logic [31:0] A1 = 32'hA000_0D13, A2 = 32'hA000_0E14, S1 = 32'h0000_00F1;
  localparam logic [31:0] B1 = 32'hB000_0D13, B2 = 32'hB000_0E14, S2 = 32'h0000_00F2;
  localparam logic [31:0] C1 = 32'hC000_0D13, C2 = 32'hC000_0E14, D1 = 32'hD000_0D13;
  localparam logic [31:0] S3 = 32'h0000_00F3;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [31:0] e13, input logic [31:0] e14,
                         input logic [31:0] est, input logic [31:0] esv);
    chk(req, "r13", r13_o, e13);
    chk(req, "r14", r14_o, e14);
    chk(req, "status", stat_o, est);
    chk(req, "saved", saved_o, esv);
  endtask

  task automatic idle();
    mode_req_valid = 1'b0; mode_req_code = '0;
    reg_wr_en = 1'b0; reg_wr_sel = 1'b0; reg_wr_data = '0;
    saved_wr_en = 1'b0; saved_wr_data = '0;
    stat_wr_en = 1'b0; stat_wr_data = '0;
  endtask

  // inputs are set at a falling edge; one rising edge takes them; outputs read at next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic req(input logic [4:0] code);
    mode_req_valid = 1'b1; mode_req_code = code; step();
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d; step();
  endtask

  task automatic wr_saved(input logic [31:0] d);
    saved_wr_en = 1'b1; saved_wr_data = d; step();
  endtask

  task automatic t_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk_all("R1 in reset", 32'h1000_0000, 0, 32'h0000_00D3, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R1 after release", 32'h1000_0000, 0, 32'h0000_00D3, 0);
  endtask

  task automatic t_switch_basic();
    wr(1'b0, A1); wr(1'b1, A2); wr_saved(S1);
    chk_all("R3 svc writes", A1, A2, 32'hD3, S1);
    req(5'h12);
    chk_all("R2 R3 R4 enter irq", 0, 0, 32'hD2, 0);
    wr(1'b0, B1); wr(1'b1, B2); wr_saved(S2);
    req(5'h13);
    chk_all("R3 R4 back to svc", A1, A2, 32'hD3, S1);
    req(5'h12);
    chk_all("R3 R4 back to irq", B1, B2, 32'hD2, S2);
  endtask

  task automatic t_same_mode();
    req(5'h12);
    chk_all("R5 same mode", B1, B2, 32'hD2, S2);
  endtask

  task automatic t_bad_code();
    req(5'h00);
    chk_all("R6 code 0x00", B1, B2, 32'hD2, S2);
    req(5'h15);
    chk_all("R6 code 0x15", B1, B2, 32'hD2, S2);
  endtask

  task automatic t_user_system();
    req(5'h10);
    chk_all("R7 enter user", 0, 0, 32'hD0, S2);
    wr(1'b0, C1); wr(1'b1, C2);
    wr_saved(32'h55);
    chk("R7 saved write in user", "saved", saved_o, S2);
    req(5'h1F);
    chk_all("R7 user to system", C1, C2, 32'hDF, S2);
    wr_saved(32'h66);
    chk("R7 saved write in system", "saved", saved_o, S2);
    req(5'h10);
    chk_all("R7 system to user", C1, C2, 32'hD0, S2);
  endtask

  task automatic t_switch_write();
    mode_req_valid = 1'b1; mode_req_code = 5'h17;
    reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = D1;
    step();
    chk_all("R8 switch+write to abort", D1, 0, 32'hD7, 0);
    req(5'h10);
    chk_all("R8 user bank kept pre-write", C1, C2, 32'hD0, 0);
    req(5'h17);
    chk_all("R8 abort bank holds write", D1, 0, 32'hD7, 0);
    mode_req_valid = 1'b1; mode_req_code = 5'h11;
    saved_wr_en = 1'b1; saved_wr_data = S3;
    step();
    chk_all("R8 R4 switch+saved write to fiq", 0, 0, 32'hD1, S3);
    req(5'h17);
    chk("R4 abort slot", "saved", saved_o, 0);
    chk("R3 abort r13", "r13", r13_o, D1);
    req(5'h11);
    chk("R4 fiq slot restored", "saved", saved_o, S3);
  endtask

  task automatic t_status_write();
    stat_wr_en = 1'b1; stat_wr_data = 27'h7FF_FFF8; step();
    chk("R9 upper write", "status", stat_o, 32'hFFFF_FF11);
    req(5'h1B);
    chk("R2 keeps upper bits", "status", stat_o, 32'hFFFF_FF1B);
    stat_wr_en = 1'b1; stat_wr_data = 27'h000_0000; step();
    chk("R9 mode field kept", "status", stat_o, 32'h0000_001B);
  endtask

  initial begin
    t_reset();
    t_switch_basic();
    t_same_mode();
    t_bad_code();
    t_user_system();
    t_switch_write();
    t_status_write();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule